// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the lowest address bits of a pipelined synchronous memory while a four-beat burst is in progress. A load pulse seeds it with the low bits of the external address. After that, each clock edge that samples the active-low advance strobe as low moves it to the next beat. The address of each beat comes from the seed and a beat index. The index is combined with the seed either by bitwise XOR (interleaved order) or by modulo addition (linear order). A mode input selects which.

The memory controller puts the upper address bits beside this block's output. Read bursts and write bursts use the same sequence, so the block has no notion of direction. The burst width is a parameter. The default of two bits gives a four-address window that the burst never leaves.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high at a rising edge, the next cycle shows addr_o = 0 and beat_o = 0.
- R2: A load_i high at a rising edge makes the following cycle show beat_o = 0 and addr_o equal to the start_addr_i sampled at that edge, in either mode.
- R3: When load_i and an active advance (adv_n_i = 0) are sampled at the same edge, the load wins: beat_o becomes 0 and nothing is stepped.
- R4: When adv_n_i is 0 and load_i is 0 at a rising edge, beat_o increments by one, modulo 4.
- R5: With mode_i = 1 (interleaved), addr_o equals the seed XOR beat_o. For example, seed 01 gives 01,00,11,10 and seed 10 gives 10,11,00,01.
- R6: With mode_i = 0 (linear), addr_o equals (seed + beat_o) modulo 4. For example, seed 01 gives 01,10,11,00 and seed 11 gives 11,00,01,10.
- R7: When adv_n_i is 1 and load_i is 0 at an edge, beat_o holds, and so does addr_o while mode_i is unchanged.
- R8: An advance sampled while beat_o = 3 wraps beat_o to 0 and addr_o back to the seed, so the address never leaves the four-address window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Starts a burst by capturing start_addr_i |
| start_addr_i | input | BURST_W | Low bits of the external address, taken as the seed |
| adv_n_i | input | 1 | Active-low advance strobe |
| mode_i | input | 1 | Order select: 1 for interleaved, 0 for linear |
| addr_o | output | BURST_W | Current burst address bits |
| beat_o | output | BURST_W | Index of the current beat within the burst |

## Verification
The seed and the beat index are registers, so the effect of a load, an advance or a reset sampled at one rising edge appears in the cycle that follows it, one edge later. addr_o is a combinational map of those registers and mode_i, so a change of mode alters it in the same cycle, with no clock involved. The bench drives every input on the falling edge and lets one rising edge pass. It compares both outputs on the next falling edge against a model that it advances at that same rising edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic seed_we;
        logic clear;
        logic step;
    } burst_ctl_t;

    function automatic burst_ctl_t decode_ctl(input logic load, input logic adv_n);
        burst_ctl_t c;
        c.seed_we = load;
        c.clear   = load;
        c.step    = !load && !adv_n;
        return c;
    endfunction

endpackage

// File: rtl/burst_seed_reg.sv
module burst_seed_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] beat
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) beat <= '0;
        else if (step)    beat <= beat + ONE;
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int W = 2
) (
    input  order_e       order,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] beat,
    output logic [W-1:0] addr
);
    logic [W-1:0] lin_addr;
    logic [W-1:0] ilv_addr;

    assign lin_addr = seed + beat;

    for (genvar b = 0; b < W; b++) begin : g_ilv
        assign ilv_addr[b] = seed[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: addr = ilv_addr;
            default:        addr = lin_addr;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int BURST_W = burst_pkg::BURST_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [BURST_W-1:0] start_addr_i,
    input  logic               adv_n_i,
    input  logic               mode_i,
    output logic [BURST_W-1:0] addr_o,
    output logic [BURST_W-1:0] beat_o
);
    burst_ctl_t         ctl;
    order_e             order;
    logic [BURST_W-1:0] seed_q;

    assign ctl   = decode_ctl(load_i, adv_n_i);
    assign order = order_e'(mode_i);

    burst_seed_reg #(.W(BURST_W)) u_seed (
        .clk (clk),
        .rst (rst),
        .we  (ctl.seed_we),
        .d   (start_addr_i),
        .q   (seed_q)
    );

    burst_beat_cnt #(.W(BURST_W)) u_beat (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.clear),
        .step  (ctl.step),
        .beat  (beat_o)
    );

    burst_order_map #(.W(BURST_W)) u_map (
        .order (order),
        .seed  (seed_q),
        .beat  (beat_o),
        .addr  (addr_o)
    );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int BURST_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               load_i,
    input logic [BURST_W-1:0] start_addr_i,
    input logic               adv_n_i,
    input logic               mode_i,
    input logic [BURST_W-1:0] addr_o,
    input logic [BURST_W-1:0] beat_o
);
    logic [BURST_W-1:0] shadow_seed;

    always_ff @(posedge clk) begin
        if (rst)         shadow_seed <= '0;
        else if (load_i) shadow_seed <= start_addr_i;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_o == '0 && beat_o == '0));

    // R2
    load_seed_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (beat_o == '0 && addr_o == $past(start_addr_i)));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !adv_n_i) |=> beat_o == '0);

    // R4
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i) |=> beat_o == BURST_W'($past(beat_o) + 1'b1));

    // R5
    interleave_map_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i |-> addr_o == (shadow_seed ^ beat_o));

    // R6
    linear_map_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_i |-> addr_o == BURST_W'(shadow_seed + beat_o));

    // R7
    hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=> $stable(beat_o));

    // R8
    wrap_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i && beat_o == {BURST_W{1'b1}}) |=>
            (beat_o == '0 && addr_o == shadow_seed));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.BURST_W(BURST_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .adv_n_i      (adv_n_i),
    .mode_i       (mode_i),
    .addr_o       (addr_o),
    .beat_o       (beat_o)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [W-1:0] start_addr_i = '0;
    logic         adv_n_i = 1'b1;
    logic         mode_i = 1'b0;
    logic [W-1:0] addr_o;
    logic [W-1:0] beat_o;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_seed = '0;
    logic [W-1:0] m_beat = '0;

    always #5 clk = ~clk;

    burst_addr_gen #(.BURST_W(W)) dut (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .start_addr_i (start_addr_i),
        .adv_n_i      (adv_n_i),
        .mode_i       (mode_i),
        .addr_o       (addr_o),
        .beat_o       (beat_o)
    );

    function automatic logic [W-1:0] exp_addr(input logic [W-1:0] s,
                                              input logic [W-1:0] b,
                                              input logic m);
        if (m) return s ^ b;
        return W'(s + b);
    endfunction

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, pass one rising edge, check at the next falling edge.
    task automatic step(input logic ld, input logic [W-1:0] sa,
                        input logic advn, input logic md, input string beat_req);
        load_i = ld; start_addr_i = sa; adv_n_i = advn; mode_i = md;
        @(posedge clk);
        if (ld) begin
            m_seed = sa;
            m_beat = '0;
        end else if (!advn) begin
            m_beat = W'(m_beat + 1);
        end
        @(negedge clk);
        check(beat_req, "beat_o", int'(beat_o), int'(m_beat));
        check(md ? "R5" : "R6", "addr_o", int'(addr_o), int'(exp_addr(m_seed, m_beat, md)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: timeout actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared by reset
        check("R1", "addr_o after reset", int'(addr_o), 0);
        check("R1", "beat_o after reset", int'(beat_o), 0);
        rst = 1'b0;

        // R2, R5, R8: every interleaved start, four beats, then wrap
        for (int s = 0; s < 4; s++) begin
            step(1'b1, W'(s), 1'b1, 1'b1, "R2");
            for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, 1'b1, "R4");
            step(1'b0, '0, 1'b0, 1'b1, "R8");
            check("R8", "addr_o back at seed", int'(addr_o), s);
        end

        // R2, R6, R8: every linear start
        for (int s = 0; s < 4; s++) begin
            step(1'b1, W'(s), 1'b1, 1'b0, "R2");
            for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, 1'b0, "R4");
            step(1'b0, '0, 1'b0, 1'b0, "R8");
            check("R8", "addr_o back at seed", int'(addr_o), s);
        end

        // R7: hold in mid-burst
        step(1'b1, 2'd3, 1'b1, 1'b0, "R2");
        step(1'b0, '0, 1'b0, 1'b0, "R4");
        for (int k = 0; k < 3; k++) step(1'b0, 2'd1, 1'b1, 1'b0, "R7");
        check("R7", "addr_o held", int'(addr_o), 0);

        // R3: load together with advance
        step(1'b0, '0, 1'b0, 1'b1, "R4");
        step(1'b1, 2'd2, 1'b0, 1'b1, "R3");
        check("R3", "addr_o equals new seed", int'(addr_o), 2);

        // Random mix; mode changes only at a load
        begin
            logic md = 1'b0;
            for (int n = 0; n < 400; n++) begin
                logic ld;
                logic advn;
                logic [W-1:0] sa;
                string req;
                ld   = ($urandom_range(0, 5) == 0);
                advn = ($urandom_range(0, 2) == 0);
                sa   = W'($urandom_range(0, 3));
                if (ld) md = $urandom_range(0, 1) == 1;
                if (ld && !advn)       req = "R3";
                else if (ld)           req = "R2";
                else if (advn)         req = "R7";
                else if (m_beat == 3)  req = "R8";
                else                   req = "R4";
                step(ld, sa, advn, md, req);
            end
        end

        // R1: reset in the middle of a burst
        step(1'b1, 2'd1, 1'b1, 1'b1, "R2");
        step(1'b0, '0, 1'b0, 1'b1, "R4");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "beat_o after mid-burst reset", int'(beat_o), 0);
        check("R1", "addr_o after mid-burst reset", int'(addr_o), 0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule